// File: doc/BRIEF.md
# Debug Breakpoint and Trigger Unit

This block sits beside a processor core and watches the instruction-address bus and the data bus, which carries the address, the data value and a load/store flag. Four comparators each test one selected bus quantity against a programmed value. A comparator can also be joined with its odd-numbered neighbour, so that together they test whether the quantity lies inside a bounded range. A match turns into one of three actions. The first is a halt request, which stays high until the debug host acknowledges it. The other two are a trace-start pulse and a trace-stop pulse, each one cycle long.

Each trigger works at one of three levels. A direct trigger acts as soon as it matches, which is how a plain hardware breakpoint is built. A level-A trigger takes no action of its own; it only arms the unit. A level-B trigger acts only while the unit is armed. A small state machine holds the arming state. It has two states, ST_DISARMED and ST_ARMED, and three transitions:
- *arm*: ST_DISARMED to ST_ARMED on any enabled level-A match.
- *fire-disarm*: ST_ARMED to ST_DISARMED when a level-B trigger fires and no level-A match occurs in the same cycle.
- *host-disarm*: any state to ST_DISARMED on a write to the disarm address.

The host programs the unit through a simple register port that has a write enable, an address and write data. Every output is registered, so it appears one clock after the bus sample that caused it.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, halt_req, trace_on, trace_off and armed are low, and all comparator values and configurations are zero, so no comparator matches.
- R2: A direct-level comparator with source instruction address matches when ibus_valid is high and ibus_addr equals its value. With action halt, halt_req rises on the clock edge that samples the bus.
- R3: halt_req stays high until a cycle in which halt_ack is high, and it is low after that cycle. If a new halt firing coincides with halt_ack, halt_req stays high.
- R4: Data-address and data-value sources require dbus_valid. The qualifier limits a match to loads only (dbus_store=0), stores only (dbus_store=1) or either.
- R5: When the range bit of an even comparator 2k is set, comparator 2k matches when its value ≤ sample ≤ comparator 2k+1's value, using unsigned comparison with both bounds inclusive. Comparator 2k+1 then never matches on its own.
- R6: Any enabled level-A match moves the unit to armed (the armed output goes high) unless a disarm write occurs in the same cycle. Level-A triggers perform no action.
- R7: A level-B match has no effect while the unit is disarmed. This includes a cycle in which a level-A match arms the unit.
- R8: A level-B firing performs its action and disarms the unit. A level-A match in the same cycle keeps the unit armed.
- R9: Any write to address 2·NUM_CMP disarms the unit. This takes priority over a simultaneous level-A match, and a later level-B match then has no effect.
- R10: trace_on and trace_off are high for exactly the cycle after each sample in which a trace-start or trace-stop trigger fires.
- R11: A comparator whose enable bit is clear, or whose bus valid is low, never matches.
- R12: Comparator i's value is at address 2i and its configuration is at address 2i+1. The configuration bits are: [0] enable; [2:1] source (0 instruction address, 1 data address, 2 data value, 3 none); [4:3] qualifier (0 either, 1 load, 2 store, 3 none); [6:5] level (0 direct, 1 A, 2 B, 3 off); [8:7] action (0 halt, 1 trace-on, 2 trace-off, 3 none); [9] range. Reserved source, qualifier and level codes never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | RA_W | Register address |
| cfg_wdata | input | VAL_W | Register write data |
| ibus_valid | input | 1 | Instruction address valid |
| ibus_addr | input | VAL_W | Instruction address |
| dbus_valid | input | 1 | Data bus transfer valid |
| dbus_store | input | 1 | 1 for store, 0 for load |
| dbus_addr | input | VAL_W | Data address |
| dbus_data | input | VAL_W | Data value |
| halt_ack | input | 1 | Host acknowledge of the halt request |
| halt_req | output | 1 | Held halt request to the processor |
| trace_on | output | 1 | One-cycle trace-start pulse |
| trace_off | output | 1 | One-cycle trace-stop pulse |
| armed | output | 1 | Unit is armed for level-B triggers |

## Verification
The hardest situations to reach are the coincidences around the arming state: an A match and a B match on the same sample, once from ST_DISARMED and once from ST_ARMED, and a disarm write that lands on the same edge as an A match. The bench sets up these cases by placing the level-A trigger on the instruction bus and the level-B trigger on the data bus. It then drives both buses, and the register port when needed, within a single cycle. It reads the result from the armed and halt_req outputs.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        SRC_IADDR = 2'd0,
        SRC_DADDR = 2'd1,
        SRC_DDATA = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        QUAL_ANY   = 2'd0,
        QUAL_LOAD  = 2'd1,
        QUAL_STORE = 2'd2,
        QUAL_NONE  = 2'd3
    } qual_e;

    typedef enum logic [1:0] {
        LVL_DIRECT = 2'd0,
        LVL_A      = 2'd1,
        LVL_B      = 2'd2,
        LVL_OFF    = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ACT_HALT  = 2'd0,
        ACT_TRON  = 2'd1,
        ACT_TROFF = 2'd2,
        ACT_NONE  = 2'd3
    } act_e;

    // packed MSB first: range[9] act[8:7] lvl[6:5] qual[4:3] src[2:1] en[0]
    typedef struct packed {
        logic  range;
        act_e  act;
        lvl_e  lvl;
        qual_e qual;
        src_e  src;
        logic  en;
    } cmp_cfg_t;

    localparam int CFG_W = $bits(cmp_cfg_t);

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
    import dbg_trig_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int VAL_W   = 32,
    parameter int RA_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [RA_W-1:0]                 cfg_addr,
    input  logic [VAL_W-1:0]                cfg_wdata,
    output logic [NUM_CMP-1:0][VAL_W-1:0]   cmp_val,
    output cmp_cfg_t [NUM_CMP-1:0]          cmp_cfg,
    output logic                            disarm_cmd
);

    localparam logic [RA_W-1:0] DISARM_ADDR = RA_W'(2 * NUM_CMP);

    assign disarm_cmd = cfg_we && (cfg_addr == DISARM_ADDR);

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        localparam logic [RA_W-1:0] VAL_ADDR = RA_W'(2 * i);
        localparam logic [RA_W-1:0] CFG_ADDR = RA_W'(2 * i + 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_val[i] <= '0;
                cmp_cfg[i] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == VAL_ADDR) cmp_val[i] <= cfg_wdata;
                if (cfg_addr == CFG_ADDR) cmp_cfg[i] <= cmp_cfg_t'(cfg_wdata[CFG_W-1:0]);
            end
        end

        // R12
        val_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == VAL_ADDR) |=> (cmp_val[i] == $past(cfg_wdata)));
    end

endmodule

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
    import dbg_trig_pkg::*;
#(
    parameter int VAL_W     = 32,
    parameter bit RANGE_CAP = 1'b0
) (
    input  logic             en,
    input  src_e             src,
    input  qual_e            qual,
    input  logic             range,
    input  logic [VAL_W-1:0] lo_val,
    input  logic [VAL_W-1:0] hi_val,
    input  logic             ibus_valid,
    input  logic [VAL_W-1:0] ibus_addr,
    input  logic             dbus_valid,
    input  logic             dbus_store,
    input  logic [VAL_W-1:0] dbus_addr,
    input  logic [VAL_W-1:0] dbus_data,
    output logic             hit
);

    logic             smp_vld;
    logic             qual_ok;
    logic             val_ok;
    logic [VAL_W-1:0] smp;

    always_comb begin
        smp_vld = 1'b0;
        smp     = '0;
        qual_ok = 1'b1;
        unique case (src)
            SRC_IADDR: begin smp_vld = ibus_valid; smp = ibus_addr; end
            SRC_DADDR: begin smp_vld = dbus_valid; smp = dbus_addr; end
            SRC_DDATA: begin smp_vld = dbus_valid; smp = dbus_data; end
            default:   begin smp_vld = 1'b0;       smp = '0;        end
        endcase
        if (src != SRC_IADDR) begin
            unique case (qual)
                QUAL_ANY:   qual_ok = 1'b1;
                QUAL_LOAD:  qual_ok = !dbus_store;
                QUAL_STORE: qual_ok = dbus_store;
                default:    qual_ok = 1'b0;
            endcase
        end
        if (RANGE_CAP && range) val_ok = (smp >= lo_val) && (smp <= hi_val);
        else                    val_ok = (smp == lo_val);
        hit = en && smp_vld && qual_ok && val_ok;
    end

endmodule

// File: rtl/dbg_trig_ctl.sv
module dbg_trig_ctl
    import dbg_trig_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CMP-1:0]   hit,
    input  lvl_e [NUM_CMP-1:0]   lvl,
    input  act_e [NUM_CMP-1:0]   act,
    input  logic                 disarm_cmd,
    input  logic                 halt_ack,
    output logic                 halt_req,
    output logic                 trace_on,
    output logic                 trace_off,
    output logic                 armed
);

    arm_state_e state_q, state_d;
    logic a_hit, b_fire, f_halt, f_on, f_off;

    always_comb begin
        a_hit  = 1'b0;
        b_fire = 1'b0;
        f_halt = 1'b0;
        f_on   = 1'b0;
        f_off  = 1'b0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (hit[i]) begin
                if (lvl[i] == LVL_A) a_hit = 1'b1;
                if (lvl[i] == LVL_DIRECT || (lvl[i] == LVL_B && state_q == ST_ARMED)) begin
                    if (lvl[i] == LVL_B) b_fire = 1'b1;
                    case (act[i])
                        ACT_HALT:  f_halt = 1'b1;
                        ACT_TRON:  f_on   = 1'b1;
                        ACT_TROFF: f_off  = 1'b1;
                        default:   ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (!disarm_cmd && a_hit) state_d = ST_ARMED;
            ST_ARMED: begin
                if (disarm_cmd)           state_d = ST_DISARMED;
                else if (b_fire && !a_hit) state_d = ST_DISARMED;
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_req  <= 1'b0;
            trace_on  <= 1'b0;
            trace_off <= 1'b0;
        end else begin
            halt_req  <= f_halt || (halt_req && !halt_ack);
            trace_on  <= f_on;
            trace_off <= f_off;
        end
    end

    assign armed = (state_q == ST_ARMED);

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !halt_ack) |=> halt_req);
    // R3
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_ack && !f_halt) |=> !halt_req);
    // R6
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && !disarm_cmd) |=> armed);
    // R8
    fire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && b_fire && !a_hit && !disarm_cmd) |=> !armed);
    // R9
    host_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_cmd |=> !armed);

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int VAL_W   = 32,
    parameter int RA_W    = $clog2(2 * NUM_CMP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [RA_W-1:0]  cfg_addr,
    input  logic [VAL_W-1:0] cfg_wdata,
    input  logic             ibus_valid,
    input  logic [VAL_W-1:0] ibus_addr,
    input  logic             dbus_valid,
    input  logic             dbus_store,
    input  logic [VAL_W-1:0] dbus_addr,
    input  logic [VAL_W-1:0] dbus_data,
    input  logic             halt_ack,
    output logic             halt_req,
    output logic             trace_on,
    output logic             trace_off,
    output logic             armed
);

    logic [NUM_CMP-1:0][VAL_W-1:0] cmp_val;
    cmp_cfg_t [NUM_CMP-1:0]        cmp_cfg;
    logic                          disarm_cmd;
    logic [NUM_CMP-1:0]            raw_hit;
    logic [NUM_CMP-1:0]            hit;
    lvl_e [NUM_CMP-1:0]            cmp_lvl;
    act_e [NUM_CMP-1:0]            cmp_act;

    dbg_trig_regs #(.NUM_CMP(NUM_CMP), .VAL_W(VAL_W), .RA_W(RA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cmp_val    (cmp_val),
        .cmp_cfg    (cmp_cfg),
        .disarm_cmd (disarm_cmd)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam bit HAS_PAIR = (i % 2 == 0) && (i + 1 < NUM_CMP);
        logic [VAL_W-1:0] hi;
        if (HAS_PAIR) begin : g_pair
            assign hi = cmp_val[i+1];
        end else begin : g_solo
            assign hi = '0;
        end

        dbg_trig_cmp #(.VAL_W(VAL_W), .RANGE_CAP(HAS_PAIR)) u_cmp (
            .en         (cmp_cfg[i].en),
            .src        (cmp_cfg[i].src),
            .qual       (cmp_cfg[i].qual),
            .range      (cmp_cfg[i].range),
            .lo_val     (cmp_val[i]),
            .hi_val     (hi),
            .ibus_valid (ibus_valid),
            .ibus_addr  (ibus_addr),
            .dbus_valid (dbus_valid),
            .dbus_store (dbus_store),
            .dbus_addr  (dbus_addr),
            .dbus_data  (dbus_data),
            .hit        (raw_hit[i])
        );

        if (i % 2 == 1) begin : g_upper
            assign hit[i] = raw_hit[i] && !cmp_cfg[i-1].range;
        end else begin : g_lower
            assign hit[i] = raw_hit[i];
        end

        assign cmp_lvl[i] = cmp_cfg[i].lvl;
        assign cmp_act[i] = cmp_cfg[i].act;
    end

    dbg_trig_ctl #(.NUM_CMP(NUM_CMP)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .lvl        (cmp_lvl),
        .act        (cmp_act),
        .disarm_cmd (disarm_cmd),
        .halt_ack   (halt_ack),
        .halt_req   (halt_req),
        .trace_on   (trace_on),
        .trace_off  (trace_off),
        .armed      (armed)
    );

endmodule

// File: tb/tb_dbg_trig_unit.sv
`timescale 1ns/1ps
module tb_dbg_trig_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ibus_valid = 1'b0;
    logic [31:0] ibus_addr = '0;
    logic        dbus_valid = 1'b0;
    logic        dbus_store = 1'b0;
    logic [31:0] dbus_addr = '0;
    logic [31:0] dbus_data = '0;
    logic        halt_ack = 1'b0;
    logic        halt_req, trace_on, trace_off, armed;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dbg_trig_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ibus_valid(ibus_valid), .ibus_addr(ibus_addr),
        .dbus_valid(dbus_valid), .dbus_store(dbus_store), .dbus_addr(dbus_addr),
        .dbus_data(dbus_data), .halt_ack(halt_ack), .halt_req(halt_req),
        .trace_on(trace_on), .trace_off(trace_off), .armed(armed)
    );

    function automatic logic [31:0] cfgw(bit en, int src, int qual, int lvl, int act, bit rng);
        return 32'(en) | 32'(src << 1) | 32'(qual << 3) | 32'(lvl << 5) | 32'(act << 7) | 32'(rng << 9);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the negedge after the sampling edge
    task automatic cyc(bit iv, logic [31:0] ia, bit dv, bit st, logic [31:0] da,
                       logic [31:0] dd, bit ack, bit we, logic [3:0] wa, logic [31:0] wd);
        @(negedge clk);
        ibus_valid = iv; ibus_addr = ia; dbus_valid = dv; dbus_store = st;
        dbus_addr = da; dbus_data = dd; halt_ack = ack;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        @(negedge clk);
        ibus_valid = 0; dbus_valid = 0; dbus_store = 0; halt_ack = 0; cfg_we = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    task automatic ifetch(logic [31:0] a);
        cyc(1, a, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic daccess(bit st, logic [31:0] a, logic [31:0] d);
        cyc(0, 0, 1, st, a, d, 0, 0, 0, 0);
    endtask

    task automatic ack();
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            wr(4'(2*i+1), 0);
            wr(4'(2*i), 0);
        end
        wr(4'd8, 0);
        if (halt_req) ack();
    endtask

    task automatic t_reset();
        chk("R1 halt_req", halt_req, 0);
        chk("R1 trace_on", trace_on, 0);
        chk("R1 trace_off", trace_off, 0);
        chk("R1 armed", armed, 0);
        cyc(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R1 no match after reset", {halt_req, trace_on, trace_off, armed}, 0);
    endtask

    task automatic t_breakpoint();
        wr(4'd0, 32'h1000);
        wr(4'd1, cfgw(1, 0, 0, 0, 0, 0));
        ifetch(32'h1004);
        chk("R2 other address", halt_req, 0);
        cyc(0, 32'h1000, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R11 ibus_valid low", halt_req, 0);
        ifetch(32'h1000);
        chk("R2 breakpoint halt", halt_req, 1);
        @(negedge clk);
        chk("R3 halt held", halt_req, 1);
        cyc(1, 32'h1000, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R3 ack with new hit", halt_req, 1);
        ack();
        chk("R3 ack releases", halt_req, 0);
        wr(4'd1, cfgw(0, 0, 0, 0, 0, 0));
        ifetch(32'h1000);
        chk("R11 disabled", halt_req, 0);
        clear_all();
    endtask

    task automatic t_data_qual();
        wr(4'd4, 32'h2000);
        wr(4'd5, cfgw(1, 1, 2, 0, 1, 0));
        wr(4'd6, 32'hDEAD);
        wr(4'd7, cfgw(1, 2, 1, 0, 2, 0));
        daccess(0, 32'h2000, 0);
        chk("R4 load ignored by store qualifier", trace_on, 0);
        daccess(1, 32'h2000, 0);
        chk("R4 store matches", trace_on, 1);
        @(negedge clk);
        chk("R10 trace_on one cycle", trace_on, 0);
        daccess(1, 32'h10, 32'hDEAD);
        chk("R4 store ignored by load qualifier", trace_off, 0);
        daccess(0, 32'h10, 32'hDEAD);
        chk("R4 load data matches", trace_off, 1);
        @(negedge clk);
        chk("R10 trace_off one cycle", trace_off, 0);
        clear_all();
    endtask

    task automatic t_range();
        wr(4'd0, 32'h100);
        wr(4'd2, 32'h1FF);
        wr(4'd1, cfgw(1, 0, 0, 0, 1, 1));
        wr(4'd3, cfgw(1, 0, 0, 0, 0, 0));
        ifetch(32'hFF);
        chk("R5 below low", trace_on, 0);
        ifetch(32'h100);
        chk("R5 low bound inclusive", trace_on, 1);
        ifetch(32'h1FF);
        chk("R5 high bound inclusive", trace_on, 1);
        chk("R5 upper comparator suppressed", halt_req, 0);
        ifetch(32'h200);
        chk("R5 above high", trace_on, 0);
        ifetch(32'h8000_0150);
        chk("R5 unsigned compare", trace_on, 0);
        clear_all();
    endtask

    task automatic t_two_level();
        wr(4'd0, 32'h40);
        wr(4'd1, cfgw(1, 0, 0, 1, 0, 0));
        wr(4'd2, 32'h300);
        wr(4'd3, cfgw(1, 1, 0, 2, 0, 0));
        daccess(0, 32'h300, 0);
        chk("R7 B while disarmed", halt_req, 0);
        cyc(1, 32'h40, 1, 0, 32'h300, 0, 0, 0, 0, 0);
        chk("R7 same-cycle A and B no fire", halt_req, 0);
        chk("R6 A arms", armed, 1);
        daccess(1, 32'h300, 0);
        chk("R8 B fires when armed", halt_req, 1);
        chk("R8 firing disarms", armed, 0);
        ack();
        ifetch(32'h40);
        chk("R6 rearm", armed, 1);
        wr(4'd8, 0);
        chk("R9 host disarm", armed, 0);
        daccess(0, 32'h300, 0);
        chk("R9 B ignored after disarm", halt_req, 0);
        ifetch(32'h40);
        cyc(1, 32'h40, 1, 0, 32'h300, 0, 0, 0, 0, 0);
        chk("R8 fire with A", halt_req, 1);
        chk("R8 A keeps armed", armed, 1);
        ack();
        cyc(1, 32'h40, 0, 0, 0, 0, 0, 1, 4'd8, 0);
        chk("R9 disarm beats A", armed, 0);
        clear_all();
        wr(4'd5, cfgw(1, 3, 0, 0, 0, 0));
        cyc(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R12 reserved source never matches", halt_req, 0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_breakpoint();
        t_data_qual();
        t_range();
        t_two_level();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule